// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block turns one request into a complete page-mode access on a single EDO DRAM bank. A request names one row and a burst of one to `N_BEATS` columns. It also carries a read or write flag and one write word for each column. The sequencer drives the row strobe, column strobe, write enable and multiplexed address lines, and it returns read data one word per column.

The block runs on a clock at twice the memory rate. Every tick is therefore half a memory clock, and every delay below is given in ticks. A three-field configuration word sets the timing. The timing field sets the row precharge time, the row-address lead time and the row-address hold time, and it also shapes the row-to-column delay. The fast bit shortens the row-to-column delay. The cycle field sets a minimum overall row cycle, which the block meets by stretching the time the row strobe stays low.

Requests use a valid/ready handshake. The block accepts a request on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` goes low at that edge and stays low until the row strobe has risen and the precharge time has passed. A requester that holds `req_valid` high is accepted on the first edge where the block is idle. Read data has no back-pressure: the consumer must take each `rd_valid` beat in the tick it appears.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, `req_ready`=1, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: The block accepts a request on an edge where `req_valid` and `req_ready` are both high. At that edge it latches the row, the columns, the write data, the length, the direction and the configuration. Changing any input after acceptance has no effect on the access in progress.
- R3: After acceptance, the row strobe stays high for T_su ticks while `mem_addr` holds the row, then falls. T_su is 5 for timing field 00 or 11, 4 for 01 and 3 for 10.
- R4: After the row strobe falls, `mem_addr` keeps the row for T_rh ticks and then shows column 0. T_rh is 2 for timing field 01 and 1 for any other value.
- R5: The first column strobe falls T_rcd ticks after the row strobe falls. T_rcd is 3 for timing field 01, 2 when the fast bit is 1, and 4 otherwise.
- R6: `req_len` value k gives k+1 column beats. Each beat is one tick with the column strobe low followed by one tick with it high. During the low tick, `mem_addr` shows that beat's column. During the high tick it shows the next beat's column, or keeps the current column after the last beat. Columns are packed with column i at `req_cols[i*ADDR_W +: ADDR_W]`.
- R7: The row strobe stays low for max(T_rcd + 2·beats, T_cyc − T_pre) ticks and rises only while the column strobe is high. T_cyc is 8 for cycle field 01, 6 for 10, and 10 for 00 or 11.
- R8: After the row strobe rises, it stays high for T_pre ticks before `req_ready` returns. T_pre is 4 for timing field 00 or 11, 3 for 01 and 2 for 10.
- R9: On a write, `mem_we_n`=0 and `mem_dq_oe`=1 for the whole time the row strobe is low, and both are inactive at all other times. `mem_dq_out` carries the write word of the column on `mem_addr`, packed like the columns.
- R10: On a read, `mem_dq_in` is sampled at the end of each beat's column-strobe-high tick. `rd_valid` pulses for one tick in the tick that follows, with that word on `rd_data`. Each access gives exactly one pulse per beat, in column order. A write gives none.
- R11: The column strobe is never low while the row strobe is high, and it is low for only one tick at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cycle | input | 2 | Minimum row-cycle select |
| cfg_timing | input | 2 | Precharge, row lead/hold and row-to-column select |
| cfg_fast | input | 1 | Short row-to-column delay |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_len | input | LEN_W | Number of beats minus one |
| req_row | input | ADDR_W | Row address |
| req_cols | input | N_BEATS*ADDR_W | Packed column addresses |
| req_wdata | input | N_BEATS*DATA_W | Packed write words |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| mem_dq_out | output | DATA_W | Write data to the memory |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_in | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Read beat valid (one tick) |
| rd_data | output | DATA_W | Read beat data |

## Verification
The assertions assume the memory holds `mem_dq_in` steady from the column-strobe-low tick until the capture edge, which is what an EDO part does. They also assume `req_len` never exceeds `N_BEATS`−1. The stimulus sweeps every cycle, timing and fast setting, both directions and every burst length. For each beat its memory model presents a word computed from the row and column, and it holds that word until the next column strobe. After each acceptance the bench drives conflicting configuration values, so the latched settings alone must produce the timings it counts.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RCD,
    ST_CLO,
    ST_CHI,
    ST_HOLD,
    ST_PRE
  } seq_state_t;

  localparam int TICK_W = 4;

  // All delays are counted in half memory clocks (ticks)
  typedef struct packed {
    logic [TICK_W-1:0] setup;
    logic [TICK_W-1:0] hold;
    logic [TICK_W-1:0] rcd;
    logic [TICK_W-1:0] pre;
    logic [TICK_W-1:0] ras_min;
  } edo_tim_t;

endpackage

// File: rtl/edo_timing_decode.sv
module edo_timing_decode
  import edo_seq_pkg::*;
(
  input  logic [1:0] cycle_sel,
  input  logic [1:0] timing_sel,
  input  logic       fast_rcd,
  output edo_tim_t   tim
);

  logic [TICK_W-1:0] cyc_ticks;

  always_comb begin
    case (cycle_sel)
      2'b01:   cyc_ticks = 4'd8;
      2'b10:   cyc_ticks = 4'd6;
      default: cyc_ticks = 4'd10;
    endcase

    case (timing_sel)
      2'b01: begin
        tim.setup = 4'd4;
        tim.hold  = 4'd2;
        tim.rcd   = 4'd3;
        tim.pre   = 4'd3;
      end
      2'b10: begin
        tim.setup = 4'd3;
        tim.hold  = 4'd1;
        tim.rcd   = fast_rcd ? 4'd2 : 4'd4;
        tim.pre   = 4'd2;
      end
      default: begin
        tim.setup = 4'd5;
        tim.hold  = 4'd1;
        tim.rcd   = fast_rcd ? 4'd2 : 4'd4;
        tim.pre   = 4'd4;
      end
    endcase

    tim.ras_min = cyc_ticks - tim.pre;
  end

endmodule

// File: rtl/edo_beat_mux.sv
module edo_beat_mux #(
  parameter int N_BEATS = 4,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (N_BEATS > 1) ? $clog2(N_BEATS) : 1
) (
  input  logic [N_BEATS*ADDR_W-1:0] cols,
  input  logic [N_BEATS*DATA_W-1:0] words,
  input  logic [IDX_W-1:0]          idx,
  output logic [ADDR_W-1:0]         col,
  output logic [DATA_W-1:0]         word
);

  logic [ADDR_W-1:0] col_arr  [N_BEATS];
  logic [DATA_W-1:0] word_arr [N_BEATS];

  for (genvar g = 0; g < N_BEATS; g++) begin : g_unpack
    assign col_arr[g]  = cols[g*ADDR_W +: ADDR_W];
    assign word_arr[g] = words[g*DATA_W +: DATA_W];
  end

  assign col  = col_arr[idx];
  assign word = word_arr[idx];

endmodule

// File: rtl/edo_seq_ctrl.sv
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int N_BEATS = 4,
  localparam int IDX_W  = (N_BEATS > 1) ? $clog2(N_BEATS) : 1,
  localparam int EL_W   = $clog2(2*N_BEATS + 10) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_len,
  input  edo_tim_t         tim_in,
  output logic             req_ready,
  output logic             accept,
  output logic             ras_low,
  output logic             cas_low,
  output logic             row_phase,
  output logic             write_q,
  output logic             capture,
  output logic [IDX_W-1:0] idx
);

  seq_state_t        state_q;
  logic [TICK_W-1:0] cnt_q;
  logic [EL_W-1:0]   el_q;
  logic [EL_W-1:0]   el_nxt;
  logic [IDX_W-1:0]  beat_q;
  logic [IDX_W-1:0]  last_q;
  edo_tim_t          tim_q;
  logic              ras_done;

  assign el_nxt   = el_q + 1'b1;
  assign ras_done = el_nxt >= EL_W'(tim_q.ras_min);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      el_q    <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      write_q <= 1'b0;
      tim_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          tim_q   <= tim_in;
          write_q <= req_write;
          last_q  <= req_len;
          beat_q  <= '0;
          cnt_q   <= tim_in.setup - 4'd1;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            cnt_q   <= tim_q.rcd - 4'd1;
            el_q    <= '0;
            state_q <= ST_RCD;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        ST_RCD: begin
          el_q <= el_nxt;
          if (cnt_q == '0) state_q <= ST_CLO;
          else             cnt_q   <= cnt_q - 4'd1;
        end
        ST_CLO: begin
          el_q    <= el_nxt;
          state_q <= ST_CHI;
        end
        ST_CHI: begin
          el_q <= el_nxt;
          if (beat_q != last_q) begin
            beat_q  <= beat_q + 1'b1;
            state_q <= ST_CLO;
          end else if (ras_done) begin
            cnt_q   <= tim_q.pre - 4'd1;
            state_q <= ST_PRE;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          el_q <= el_nxt;
          if (ras_done) begin
            cnt_q   <= tim_q.pre - 4'd1;
            state_q <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 4'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign ras_low   = (state_q == ST_RCD) || (state_q == ST_CLO) ||
                     (state_q == ST_CHI) || (state_q == ST_HOLD);
  assign cas_low   = (state_q == ST_CLO);
  assign row_phase = !ras_low || ((state_q == ST_RCD) && (el_q < EL_W'(tim_q.hold)));
  assign capture   = (state_q == ST_CHI) && !write_q;

  always_comb begin
    case (state_q)
      ST_CLO:  idx = beat_q;
      ST_CHI:  idx = (beat_q != last_q) ? beat_q + 1'b1 : beat_q;
      ST_HOLD: idx = beat_q;
      default: idx = '0;
    endcase
  end

  AST_CAS_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cas_low |=> !cas_low); // R11
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_low) |-> $past(ras_low)); // R11
  AST_RAS_FALL_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_low) |-> !cas_low); // R5
  AST_RAS_RISE_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_low) |-> !$past(cas_low)); // R7
  AST_READY_WAITS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_low) |-> !req_ready); // R8
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2
  AST_READY_RAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ras_low && !cas_low); // R8

endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
  import edo_seq_pkg::*;
#(
  parameter int N_BEATS = 4,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  localparam int LEN_W  = (N_BEATS > 1) ? $clog2(N_BEATS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cfg_cycle,
  input  logic [1:0]                cfg_timing,
  input  logic                      cfg_fast,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [ADDR_W-1:0]         req_row,
  input  logic [N_BEATS*ADDR_W-1:0] req_cols,
  input  logic [N_BEATS*DATA_W-1:0] req_wdata,
  output logic                      mem_ras_n,
  output logic                      mem_cas_n,
  output logic                      mem_we_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_dq_out,
  output logic                      mem_dq_oe,
  input  logic [DATA_W-1:0]         mem_dq_in,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data
);

  edo_tim_t                  tim_dec;
  logic                      accept;
  logic                      ras_low;
  logic                      cas_low;
  logic                      row_phase;
  logic                      write_q;
  logic                      capture;
  logic [LEN_W-1:0]          idx;
  logic [ADDR_W-1:0]         row_q;
  logic [N_BEATS*ADDR_W-1:0] cols_q;
  logic [N_BEATS*DATA_W-1:0] words_q;
  logic [ADDR_W-1:0]         sel_col;
  logic [DATA_W-1:0]         sel_word;

  edo_timing_decode u_dec (
    .cycle_sel  (cfg_cycle),
    .timing_sel (cfg_timing),
    .fast_rcd   (cfg_fast),
    .tim        (tim_dec)
  );

  edo_seq_ctrl #(.N_BEATS(N_BEATS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_len   (req_len),
    .tim_in    (tim_dec),
    .req_ready (req_ready),
    .accept    (accept),
    .ras_low   (ras_low),
    .cas_low   (cas_low),
    .row_phase (row_phase),
    .write_q   (write_q),
    .capture   (capture),
    .idx       (idx)
  );

  edo_beat_mux #(.N_BEATS(N_BEATS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .cols  (cols_q),
    .words (words_q),
    .idx   (idx),
    .col   (sel_col),
    .word  (sel_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      cols_q  <= '0;
      words_q <= '0;
    end else if (accept) begin
      row_q   <= req_row;
      cols_q  <= req_cols;
      words_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq_in;
    end
  end

  assign mem_ras_n  = !ras_low;
  assign mem_cas_n  = !cas_low;
  assign mem_we_n   = !(ras_low && write_q);
  assign mem_dq_oe  = ras_low && write_q;
  assign mem_addr   = row_phase ? row_q : sel_col;
  assign mem_dq_out = sel_word;

  AST_ROW_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> $stable(mem_addr)); // R4
  AST_SETUP_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ras_n && !req_ready && $past(mem_ras_n && !req_ready) && !$rose(mem_ras_n))
      |-> $stable(mem_addr)); // R3
  AST_COL_HELD_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> $stable(mem_addr)); // R6
  AST_WE_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ras_n && mem_dq_oe); // R9
  AST_RDV_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !write_q && $past(!mem_cas_n, 2)); // R10

endmodule

// File: tb/edo_page_seq_test.sv
`timescale 1ns/1ps
module edo_page_seq_test;

  localparam int NB = 4;
  localparam int AW = 9;
  localparam int DW = 16;
  localparam int LW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_cycle = '0;
  logic [1:0]        cfg_timing = '0;
  logic              cfg_fast = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [LW-1:0]     req_len = '0;
  logic [AW-1:0]     req_row = '0;
  logic [NB*AW-1:0]  req_cols = '0;
  logic [NB*DW-1:0]  req_wdata = '0;
  logic              mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_dq_out;
  logic [DW-1:0]     mem_dq_in = '0;
  logic              rd_valid;
  logic [DW-1:0]     rd_data;

  int total = 0;
  int bad = 0;
  int rdv_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  edo_page_seq #(.N_BEATS(NB), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cycle(cfg_cycle), .cfg_timing(cfg_timing),
    .cfg_fast(cfg_fast), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_len(req_len), .req_row(req_row),
    .req_cols(req_cols), .req_wdata(req_wdata), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(negedge clk) if (rst_n && rd_valid) rdv_seen++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] r, input logic [AW-1:0] c);
    return {r[6:0], c} ^ 16'h5A3C;
  endfunction

  task automatic run_req(input int cyc, input int tim, input int fast, input int wr,
                         input int len, input int seed);
    int tsu, trh, trcd, tpre, tcyc, low_exp, n, low, rd_before;
    logic [AW-1:0] row;
    logic [AW-1:0] col [NB];
    logic [DW-1:0] wd [NB];
    tsu  = (tim == 1) ? 4 : (tim == 2) ? 3 : 5;
    trh  = (tim == 1) ? 2 : 1;
    trcd = (tim == 1) ? 3 : (fast != 0) ? 2 : 4;
    tpre = (tim == 1) ? 3 : (tim == 2) ? 2 : 4;
    tcyc = (cyc == 1) ? 8 : (cyc == 2) ? 6 : 10;
    low_exp = (trcd + 2*len > tcyc - tpre) ? trcd + 2*len : tcyc - tpre;
    row = AW'(seed * 13 + 5);
    for (int i = 0; i < NB; i++) begin
      col[i] = AW'(seed * 7 + i * 37 + 3);
      wd[i]  = DW'(seed * 911 + i * 4099 + 17);
      req_cols[i*AW +: AW]  = col[i];
      req_wdata[i*DW +: DW] = wd[i];
    end
    rd_before  = rdv_seen;
    cfg_cycle  = 2'(cyc);
    cfg_timing = 2'(tim);
    cfg_fast   = fast[0];
    req_write  = wr[0];
    req_len    = LW'(len - 1);
    req_row    = row;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R2: scramble every input after acceptance
    req_valid  = 1'b0;
    cfg_cycle  = ~cfg_cycle;
    cfg_timing = ~cfg_timing;
    cfg_fast   = ~cfg_fast;
    req_write  = ~req_write;
    req_len    = ~req_len;
    req_row    = ~req_row;
    req_cols   = ~req_cols;
    req_wdata  = ~req_wdata;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    n = 0;
    while (mem_ras_n) begin
      chk(mem_addr == row, "R3 row on addr during setup", mem_addr, row);
      n++;
      @(negedge clk);
    end
    chk(n == tsu, "R3 row setup ticks", n, tsu);
    n = 0;
    while (mem_cas_n) begin
      chk(mem_addr == ((n < trh) ? row : col[0]), "R4 row hold then col0",
          mem_addr, (n < trh) ? row : col[0]);
      chk(mem_we_n == (wr == 0) && mem_dq_oe == (wr != 0), "R9 we/oe during ras", mem_we_n, wr == 0);
      n++;
      @(negedge clk);
    end
    chk(n == trcd, "R5 ras to cas ticks", n, trcd);
    low = n;
    for (int b = 0; b < len; b++) begin
      chk(mem_cas_n == 1'b0 && mem_ras_n == 1'b0, "R11 cas low inside ras", mem_cas_n, 0);
      chk(mem_addr == col[b], "R6 column during cas low", mem_addr, col[b]);
      if (wr != 0) chk(mem_dq_out == wd[b] && !mem_we_n, "R9 write word", mem_dq_out, wd[b]);
      else mem_dq_in = pat(row, mem_addr);
      @(negedge clk);
      chk(mem_cas_n == 1'b1, "R6 cas high half", mem_cas_n, 1);
      chk(mem_addr == col[(b < len-1) ? b+1 : b], "R6 next column setup",
          mem_addr, col[(b < len-1) ? b+1 : b]);
      @(negedge clk);
      low += 2;
      if (wr == 0)
        chk(rd_valid == 1'b1 && rd_data == pat(row, col[b]), "R10 read beat data",
            rd_data, pat(row, col[b]));
    end
    while (!mem_ras_n) begin
      chk(mem_cas_n == 1'b1, "R7 cas high while ras held", mem_cas_n, 1);
      low++;
      @(negedge clk);
    end
    chk(low == low_exp, "R7 ras low ticks", low, low_exp);
    n = 0;
    while (!req_ready) begin
      chk(mem_ras_n && mem_we_n && !mem_dq_oe, "R9 we idle in precharge", mem_we_n, 1);
      n++;
      @(negedge clk);
    end
    chk(n == tpre, "R8 precharge ticks", n, tpre);
    chk(rdv_seen - rd_before == ((wr != 0) ? 0 : len), "R10 read beat count",
        rdv_seen - rd_before, (wr != 0) ? 0 : len);
  endtask

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R1 strobes idle", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rd_valid, "R1 oe and rd_valid low", {mem_dq_oe, rd_valid}, 0);
    for (int cy = 0; cy < 4; cy++)
      for (int tm = 0; tm < 4; tm++)
        for (int fs = 0; fs < 2; fs++)
          for (int w = 0; w < 2; w++)
            for (int ln = 1; ln <= NB; ln++) begin
              if (seed % 3 == 0) repeat (2) @(negedge clk);
              run_req(cy, tm, fs, w, ln, seed);
              seed++;
            end
    chk(req_ready == 1'b1, "R2 idle at end", req_ready, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule